// File: doc/BRIEF.md
# GPIO Bank with Lock-Gated Pad Modes

This block is one bank of general-purpose I/O pins behind a 32-bit register interface. Each implemented pin has an output data bit, a synchronised input bit and a two-bit pad mode. The mode is split across two registers, a low-half register and a high-half register. Together they choose one of four pad behaviours: input only, push-pull output, low-only drive (open drain) or high-only drive (open source). Software can update the output data register through separate set and clear aliases, so a single write changes chosen pins without a read-modify-write. The mode registers have aliases too.

Mode registers are protected by an external lock. Any write that would change the low or high mode half, directly or through an alias, lands only in the cycle in which the lock write-enable input is high. At other times such writes are dropped without any indication, while the mode registers stay readable. A parameter sets how many of the 32 bit positions carry real pins, so a short final bank can use the same block. Pad values are read back through a two-flop synchroniser.

Writes take effect on the rising clock edge at which `bus_we` is high. Reads are combinational from `bus_addr`. The pad outputs follow the registers combinationally.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every mode bit is 0 (input), every output data bit is 0, and no pad is driven (`pad_oe` all 0).
- R2: A write at offset 0x00 loads output data, at 0x08 loads the high mode half and at 0x0C loads the low mode half. Reads at these offsets return the register. Reads at the alias offsets and at unmapped offsets return 0.
- R3: A write at 0x14 sets the output data bits where the write data is 1. A write at 0x18 clears them. Bits written 0 are unchanged.
- R4: A write at 0x50 clears high-mode bits where the data is 1. A write at 0x54 sets low-mode bits where the data is 1. A write at 0x58 clears low-mode bits where the data is 1.
- R5: Writes at 0x08, 0x0C, 0x50, 0x54 and 0x58 with `lock_we` low leave both mode halves unchanged. Output data writes are unaffected by `lock_we`.
- R6: Mode {high,low}=00 never drives the pad. `pad_oe`=0 and `pad_out`=0, whatever the data bit holds.
- R7: Mode 01 drives the pad push-pull. `pad_oe`=1 and `pad_out` equals the data bit.
- R8: Mode 10 drives low only. A data bit of 0 gives `pad_oe`=1 with `pad_out`=0. A data bit of 1 gives `pad_oe`=0. `pad_out` is always 0.
- R9: Mode 11 drives high only. A data bit of 1 gives `pad_oe`=1 with `pad_out`=1. A data bit of 0 gives `pad_oe`=0. `pad_out` is always 1.
- R10: A read at 0x04 returns `pad_in` as sampled by two flops. A change is visible after the second rising edge and not after the first. Writes at 0x04 change nothing.
- R11: Read-data bits at positions NUM_PINS and above are always 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| lock_we | input | 1 | Mode write enable from the lock block |
| pad_in | input | NUM_PINS | Pad input values |
| pad_out | output | NUM_PINS | Value driven onto each pad |
| pad_oe | output | NUM_PINS | Drive enable for each pad |

## Verification
On every cycle the assertions check four things. The pad drive rules hold for every mode: no drive in input mode, constant drive in push-pull, never high in low-only mode and never low in high-only mode. The mode halves stay put in any cycle whose lock input was low. A set-alias write leaves the written bits at 1. Unimplemented read-data bits are 0. Only the bench scenarios can show the register decoding and readback at each offset, and the effect of each alias on neighbouring bits. They also show the exact two-edge latency of the input synchroniser and that writes to the input register are ignored.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int BUS_W  = 32;
   localparam int ADDR_W = 8;

   localparam logic [ADDR_W-1:0] OFS_DOUT    = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_DIN     = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_MHI     = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_MLO     = 8'h0C;
   localparam logic [ADDR_W-1:0] OFS_DSET    = 8'h14;
   localparam logic [ADDR_W-1:0] OFS_DCLR    = 8'h18;
   localparam logic [ADDR_W-1:0] OFS_MHI_CLR = 8'h50;
   localparam logic [ADDR_W-1:0] OFS_MLO_SET = 8'h54;
   localparam logic [ADDR_W-1:0] OFS_MLO_CLR = 8'h58;

   typedef enum logic [1:0] {
      PM_INPUT     = 2'b00,
      PM_PUSHPULL  = 2'b01,
      PM_LOW_ONLY  = 2'b10,
      PM_HIGH_ONLY = 2'b11
   } pad_mode_e;

   typedef struct packed {
      logic oe;
      logic val;
   } pad_drive_t;

   function automatic pad_drive_t drive_of(pad_mode_e m, logic d);
      pad_drive_t r;
      unique case (m)
         PM_INPUT:     begin r.oe = 1'b0; r.val = 1'b0; end
         PM_PUSHPULL:  begin r.oe = 1'b1; r.val = d;    end
         PM_LOW_ONLY:  begin r.oe = ~d;   r.val = 1'b0; end
         PM_HIGH_ONLY: begin r.oe = d;    r.val = 1'b1; end
         default:      begin r.oe = 1'b0; r.val = 1'b0; end
      endcase
      return r;
   endfunction
endpackage

// File: rtl/gpio_bank_bitreg.sv
module gpio_bank_bitreg #(
   parameter int W       = 32,
   parameter bit HAS_SET = 1'b1,
   parameter bit HAS_CLR = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         allow,
   input  logic         hit_load,
   input  logic         hit_set,
   input  logic         hit_clr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = q;
      if (allow) begin
         if (hit_load)
            nxt = wdata;
         else if (HAS_SET && hit_set)
            nxt = q | wdata;
         else if (HAS_CLR && hit_clr)
            nxt = q & ~wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      if (STAGES < 2) $error("gpio_bank_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[s] <= '0;
         else if (s == 0) stg[s] <= d;
         else             stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_pad.sv
module gpio_bank_pad
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input  logic [NUM_PINS-1:0] mode_hi,
   input  logic [NUM_PINS-1:0] mode_lo,
   input  logic [NUM_PINS-1:0] dout,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      pad_drive_t drv;
      always_comb drv = drive_of(pad_mode_e'({mode_hi[p], mode_lo[p]}), dout[p]);
      assign pad_out[p] = drv.val;
      assign pad_oe[p]  = drv.oe;
   end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   input  logic                lock_we,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);
   initial begin
      if (NUM_PINS < 1 || NUM_PINS > BUS_W)
         $error("gpio_bank_regs: NUM_PINS must be 1..%0d", BUS_W);
   end

   logic [NUM_PINS-1:0] wd;
   logic [NUM_PINS-1:0] data_q, mode0_q, mode1_q, din_q;
   logic hit_dout, hit_dset, hit_dclr, hit_mhi, hit_mhi_clr;
   logic hit_mlo, hit_mlo_set, hit_mlo_clr;

   assign wd          = bus_wdata[NUM_PINS-1:0];
   assign hit_dout    = bus_we && (bus_addr == OFS_DOUT);
   assign hit_dset    = bus_we && (bus_addr == OFS_DSET);
   assign hit_dclr    = bus_we && (bus_addr == OFS_DCLR);
   assign hit_mhi     = bus_we && (bus_addr == OFS_MHI);
   assign hit_mhi_clr = bus_we && (bus_addr == OFS_MHI_CLR);
   assign hit_mlo     = bus_we && (bus_addr == OFS_MLO);
   assign hit_mlo_set = bus_we && (bus_addr == OFS_MLO_SET);
   assign hit_mlo_clr = bus_we && (bus_addr == OFS_MLO_CLR);

   gpio_bank_bitreg #(.W(NUM_PINS), .HAS_SET(1'b1), .HAS_CLR(1'b1)) u_data (
      .clk(clk), .rst_n(rst_n), .allow(1'b1),
      .hit_load(hit_dout), .hit_set(hit_dset), .hit_clr(hit_dclr),
      .wdata(wd), .q(data_q));

   gpio_bank_bitreg #(.W(NUM_PINS), .HAS_SET(1'b0), .HAS_CLR(1'b1)) u_mode_hi (
      .clk(clk), .rst_n(rst_n), .allow(lock_we),
      .hit_load(hit_mhi), .hit_set(1'b0), .hit_clr(hit_mhi_clr),
      .wdata(wd), .q(mode1_q));

   gpio_bank_bitreg #(.W(NUM_PINS), .HAS_SET(1'b1), .HAS_CLR(1'b1)) u_mode_lo (
      .clk(clk), .rst_n(rst_n), .allow(lock_we),
      .hit_load(hit_mlo), .hit_set(hit_mlo_set), .hit_clr(hit_mlo_clr),
      .wdata(wd), .q(mode0_q));

   gpio_bank_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din_q));

   gpio_bank_pad #(.NUM_PINS(NUM_PINS)) u_pad (
      .mode_hi(mode1_q), .mode_lo(mode0_q), .dout(data_q),
      .pad_out(pad_out), .pad_oe(pad_oe));

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_DOUT: bus_rdata[NUM_PINS-1:0] = data_q;
         OFS_DIN:  bus_rdata[NUM_PINS-1:0] = din_q;
         OFS_MHI:  bus_rdata[NUM_PINS-1:0] = mode1_q;
         OFS_MLO:  bus_rdata[NUM_PINS-1:0] = mode0_q;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                lock_we,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [BUS_W-1:0]    bus_wdata,
   input logic [BUS_W-1:0]    bus_rdata,
   input logic [NUM_PINS-1:0] mode0_q,
   input logic [NUM_PINS-1:0] mode1_q,
   input logic [NUM_PINS-1:0] data_q,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe
);
   localparam logic [BUS_W-1:0] LIVE =
      (NUM_PINS >= BUS_W) ? '1 : BUS_W'((64'h1 << NUM_PINS) - 64'h1);

   AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      ((~mode1_q & ~mode0_q & (pad_oe | pad_out)) == '0)); // R6
   AST_PUSHPULL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      ((~mode1_q & mode0_q & (~pad_oe | (pad_out ^ data_q))) == '0)); // R7
   AST_LOW_ONLY_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode1_q & ~mode0_q & pad_out) == '0)); // R8
   AST_HIGH_ONLY_NEVER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode1_q & mode0_q & ~pad_out) == '0)); // R9
   AST_MODE_HELD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_we |=> ($stable(mode0_q) && $stable(mode1_q))); // R5
   AST_SET_ALIAS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_DSET) |=>
      ((data_q & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0]))); // R3
   AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rdata & ~LIVE) == '0)); // R11
endmodule

bind gpio_bank_regs gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .lock_we(lock_we), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .mode0_q(mode0_q), .mode1_q(mode1_q), .data_q(data_q),
   .pad_out(pad_out), .pad_oe(pad_oe));

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PINS = 20;
   localparam logic [31:0] MASK = (32'h1 << PINS) - 32'h1;

   logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, lock_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [PINS-1:0] pad_in = '0, pad_out, pad_oe;

   int errors = 0, checks = 0;
   logic [31:0] m_data = '0, m_lo = '0, m_hi = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_bank_regs #(.NUM_PINS(PINS)) u_gpio_bank_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_we(lock_we),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_pad(logic hi, logic lo, logic d); // {oe,out}
      case ({hi, lo})
         2'b00:   return 2'b00;
         2'b01:   return {1'b1, d};
         2'b10:   return {~d, 1'b0};
         default: return {d, 1'b1};
      endcase
   endfunction

   task automatic model_write(logic [7:0] a, logic [31:0] d, logic lk);
      logic [31:0] v = d & MASK;
      case (a)
         8'h00: m_data = v;
         8'h14: m_data = m_data | v;
         8'h18: m_data = m_data & ~v;
         8'h08: if (lk) m_hi = v;
         8'h50: if (lk) m_hi = m_hi & ~v;
         8'h0C: if (lk) m_lo = v;
         8'h54: if (lk) m_lo = m_lo | v;
         8'h58: if (lk) m_lo = m_lo & ~v;
         default: ;
      endcase
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d, logic lk);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1; lock_we = lk;
      @(negedge clk);
      bus_we = 1'b0; lock_we = 1'b0;
      model_write(a, d, lk);
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic check_all(string tag);
      logic [31:0] r;
      rd(8'h00, r); check({tag, " R2 data readback"}, r, m_data);
      rd(8'h08, r); check({tag, " R2 mode-hi readback"}, r, m_hi);
      rd(8'h0C, r); check({tag, " R2 mode-lo readback"}, r, m_lo);
      for (int p = 0; p < PINS; p++) begin
         logic [1:0] e = exp_pad(m_hi[p], m_lo[p], m_data[p]);
         string t;
         case ({m_hi[p], m_lo[p]})
            2'b00: t = " R6 input pad";
            2'b01: t = " R7 push-pull pad";
            2'b10: t = " R8 low-only pad";
            default: t = " R9 high-only pad";
         endcase
         check({tag, t}, {30'd0, pad_oe[p], pad_out[p]}, {30'd0, e});
      end
   endtask

   initial begin
      logic [31:0] r;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(8'h00, r); check("R1 data after reset", r, 32'h0);
      rd(8'h08, r); check("R1 mode-hi after reset", r, 32'h0);
      rd(8'h0C, r); check("R1 mode-lo after reset", r, 32'h0);
      check("R1 no pad driven", {12'd0, pad_oe}, 32'h0);

      // R2 direct loads and zero reads of aliases
      wr(8'h00, 32'hFFFF_A5A5, 1'b0); check_all("R2 load");
      rd(8'h14, r); check("R2 set alias reads 0", r, 32'h0);
      rd(8'h54, r); check("R2 mode alias reads 0", r, 32'h0);
      rd(8'h3C, r); check("R2 unmapped reads 0", r, 32'h0);
      // R11 upper bits ignored
      rd(8'h00, r); check("R11 upper data bits zero", r & ~MASK, 32'h0);

      // R3 set/clear aliases
      wr(8'h00, 32'h0000_00F0, 1'b0);
      wr(8'h14, 32'h0000_0003, 1'b0); check_all("R3 set");
      wr(8'h18, 32'h0000_0030, 1'b0); check_all("R3 clear");

      // R5 locked-out mode writes
      wr(8'h0C, 32'h000F_FFFF, 1'b0);
      wr(8'h08, 32'h000F_FFFF, 1'b0);
      wr(8'h54, 32'h0000_00FF, 1'b0);
      rd(8'h0C, r); check("R5 mode-lo unchanged unlocked", r, 32'h0);
      rd(8'h08, r); check("R5 mode-hi unchanged unlocked", r, 32'h0);

      // R4 mode aliases with lock; all four pad modes R6-R9
      wr(8'h08, 32'h0000_FF00, 1'b1);
      wr(8'h0C, 32'h0000_F0F0, 1'b1);
      check_all("R4 mode load");
      wr(8'h54, 32'h0000_000F, 1'b1); check_all("R4 mode-lo set");
      wr(8'h58, 32'h0000_0030, 1'b1); check_all("R4 mode-lo clear");
      wr(8'h50, 32'h0000_0F00, 1'b1); check_all("R4 mode-hi clear");
      wr(8'h50, 32'h0000_F000, 1'b0); check_all("R5 mode-hi clear unlocked");
      wr(8'h00, 32'h0000_AAAA, 1'b0); check_all("R8 R9 data flip");

      // R10 synchroniser latency
      @(negedge clk); pad_in = 20'hABCDE;
      @(negedge clk); rd(8'h04, r); check("R10 not visible after one edge", r, 32'h0);
      @(negedge clk); rd(8'h04, r); check("R10 visible after two edges", r, 32'h000A_BCDE);
      wr(8'h04, 32'h0, 1'b1);
      rd(8'h04, r); check("R10 input write ignored", r, 32'h000A_BCDE);
      check_all("R10 input write no side effect");

      // constrained random
      for (int i = 0; i < 300; i++) begin
         logic [7:0] addrs [9] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h18, 8'h50, 8'h54, 8'h58};
         wr(addrs[$urandom_range(8)], $urandom, 1'($urandom_range(1)));
         check_all("R2 R3 R4 R5 random");
      end
      rd(8'h08, r); check("R11 upper mode bits zero", r & ~MASK, 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule